// File: doc/BRIEF.md
# Late-Write Buffer with Read Forwarding

This block sits between a synchronous command port and a single-ported memory array. It lets a write command carry its address in one cycle and its data in the next. The write is not applied to the array straight away. Address, lane mask and data are held in a small shift buffer of `DEPTH` entries. An entry goes into the array only when a later write command arrives and finds the buffer full. With the default depth of two, a write reaches the array during the third write command. Reads are never delayed by this.

Each read address is compared with every buffered entry, lane by lane. A lane that is still buffered is taken from the buffer, and every other lane comes from the array. A write may therefore be followed at once by a read of the same address, with no idle or flush cycle between them. Each entry holds two data lanes. A double-rate write fills both lanes. A single-rate write fills only the lane chosen by `cmd_lane`, so only that lane is forwarded.

The array is taken to have a one-cycle synchronous read: `arr_rdata*` holds the word addressed by the `arr_re` cycle one clock later. `DEPTH` must be at least 2.

Top module: `late_write_buf`

## Requirements
- R1: After reset the buffer is empty, `rd_valid` and `arr_we` are low, and a read returns the array contents.
- R2: Write data is sampled from `wr_data0`/`wr_data1` in the cycle after the write command. Values on those inputs in any other cycle have no effect.
- R3: The first `DEPTH` writes after reset do not write the array. Each later write command asserts `arr_we` in its own cycle and presents the oldest buffered write's address and data.
- R4: A read command in cycle T gives `rd_valid` high in cycle T+1 with the data for that address. `rd_valid` is low in every other cycle.
- R5: A read of an address with a buffered write returns the buffered data. This includes a read issued in the same cycle as that write's data.
- R6: When several buffered entries match a read, the most recently issued write supplies each lane.
- R7: Lane 0 is `*_data0` and lane 1 is `*_data1`. `cmd_ddr`=1 writes both lanes. `cmd_ddr`=0 writes lane 0 when `cmd_lane`=0 and lane 1 when `cmd_lane`=1. A lane with no buffered write is read from the array.
- R8: `arr_wmask` bit n enables lane n, and it equals the lane set of the write being retired. It is never zero while `arr_we` is high.
- R9: Only write commands retire entries. Reads and idle cycles leave the buffer and array unchanged, and `arr_we` is never high without a write command.
- R10: During a read command `arr_re` is high with `arr_raddr` equal to `cmd_addr`. `arr_re` and `arr_we` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_ddr | input | 1 | 1 = write both lanes, 0 = one lane |
| cmd_lane | input | 1 | Lane chosen for a single-lane write |
| cmd_addr | input | AW | Word-pair address |
| wr_data0 | input | DW | Lane 0 write data, one cycle after the command |
| wr_data1 | input | DW | Lane 1 write data, one cycle after the command |
| arr_we | output | 1 | Array write strobe |
| arr_waddr | output | AW | Array write address |
| arr_wmask | output | 2 | Array lane enables |
| arr_wdata0 | output | DW | Array lane 0 write data |
| arr_wdata1 | output | DW | Array lane 1 write data |
| arr_re | output | 1 | Array read strobe |
| arr_raddr | output | AW | Array read address |
| arr_rdata0 | input | DW | Array lane 0 read data, one cycle after `arr_re` |
| arr_rdata1 | input | DW | Array lane 1 read data, one cycle after `arr_re` |
| rd_valid | output | 1 | Read result valid |
| rd_data0 | output | DW | Merged lane 0 read data |
| rd_data1 | output | DW | Merged lane 1 read data |

## Verification
The bench goes after a read issued in the very cycle that the data of a write to the same address arrives. A design without the input bypass would return the stale array word there. It also repeats writes to one address while the older copy is still buffered. Wrong match priority would return the older value, and an eviction sent to the wrong slot would leave the array one write behind. Single-lane writes are mixed with double-lane ones, so a design that forwards whole entries would corrupt the unwritten lane. Every array write is compared with the write issued `DEPTH` writes earlier, which exposes an early, late or mis-masked retirement.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
  localparam int LANES = 2;

  // lane set touched by a write command
  function automatic logic [LANES-1:0] lane_mask(input logic ddr, input logic lane);
    if (ddr) return 2'b11;
    return lane ? 2'b10 : 2'b01;
  endfunction

  // slot that receives late data: a write in the data cycle shifts it by one
  function automatic int data_slot(input logic push_now);
    return push_now ? 1 : 0;
  endfunction
endpackage

// File: rtl/lwb_store.sv
module lwb_store
  import lwb_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [AW-1:0]    push_addr,
  input  logic [LANES-1:0] push_mask,
  input  logic             data_due,
  input  logic [DW-1:0]    wdata [LANES],
  output logic [AW-1:0]    s_addr [DEPTH],
  output logic [LANES-1:0] s_mask [DEPTH],
  output logic [DW-1:0]    s_data [DEPTH][LANES],
  output logic             evict,
  output logic [AW-1:0]    ev_addr,
  output logic [LANES-1:0] ev_mask,
  output logic [DW-1:0]    ev_data [LANES]
);
  logic [AW-1:0]    n_addr [DEPTH];
  logic [LANES-1:0] n_mask [DEPTH];
  logic [DW-1:0]    n_data [DEPTH][LANES];

  assign evict   = push && (s_mask[DEPTH-1] != '0);
  assign ev_addr = s_addr[DEPTH-1];
  assign ev_mask = s_mask[DEPTH-1];
  assign ev_data = s_data[DEPTH-1];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      n_addr[i] = s_addr[i];
      n_mask[i] = s_mask[i];
      n_data[i] = s_data[i];
    end
    if (push) begin
      for (int i = DEPTH-1; i > 0; i--) begin
        n_addr[i] = s_addr[i-1];
        n_mask[i] = s_mask[i-1];
        n_data[i] = s_data[i-1];
      end
      n_addr[0] = push_addr;
      n_mask[0] = push_mask;
    end
    if (data_due) begin
      for (int l = 0; l < LANES; l++)
        n_data[data_slot(push)][l] = wdata[l];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        s_addr[i] <= '0;
        s_mask[i] <= '0;
        for (int l = 0; l < LANES; l++) s_data[i][l] <= '0;
      end
    end else begin
      s_addr <= n_addr;
      s_mask <= n_mask;
      s_data <= n_data;
    end
  end
endmodule

// File: rtl/lwb_match.sv
module lwb_match
  import lwb_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 2
) (
  input  logic [AW-1:0]    q_addr,
  input  logic [AW-1:0]    s_addr [DEPTH],
  input  logic [LANES-1:0] s_mask [DEPTH],
  input  logic [DW-1:0]    s_data [DEPTH][LANES],
  input  logic             data_due,
  input  logic [DW-1:0]    wdata [LANES],
  output logic [LANES-1:0] hit,
  output logic [DW-1:0]    fwd [LANES]
);
  // walk oldest to newest so the newest matching slot is the last writer
  always_comb begin
    hit = '0;
    for (int l = 0; l < LANES; l++) fwd[l] = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      for (int l = 0; l < LANES; l++) begin
        if (s_mask[i][l] && (s_addr[i] == q_addr)) begin
          hit[l] = 1'b1;
          fwd[l] = (i == 0 && data_due) ? wdata[l] : s_data[i][l];
        end
      end
    end
  end
endmodule

// File: rtl/lwb_merge.sv
module lwb_merge
  import lwb_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [LANES-1:0] hit,
  input  logic [DW-1:0]    fwd [LANES],
  input  logic [DW-1:0]    arr_data [LANES],
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data [LANES]
);
  logic [LANES-1:0] hit_q;
  logic [DW-1:0]    fwd_q [LANES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      hit_q    <= '0;
      for (int l = 0; l < LANES; l++) fwd_q[l] <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        hit_q <= hit;
        fwd_q <= fwd;
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++)
      rd_data[l] = hit_q[l] ? fwd_q[l] : arr_data[l];
  end
endmodule

// File: rtl/late_write_buf.sv
module late_write_buf
  import lwb_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic          cmd_ddr,
  input  logic          cmd_lane,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] wr_data0,
  input  logic [DW-1:0] wr_data1,
  output logic          arr_we,
  output logic [AW-1:0] arr_waddr,
  output logic [1:0]    arr_wmask,
  output logic [DW-1:0] arr_wdata0,
  output logic [DW-1:0] arr_wdata1,
  output logic          arr_re,
  output logic [AW-1:0] arr_raddr,
  input  logic [DW-1:0] arr_rdata0,
  input  logic [DW-1:0] arr_rdata1,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data0,
  output logic [DW-1:0] rd_data1
);
  // named events
  logic wr_cmd, rd_cmd, data_due, evict;
  assign wr_cmd = cmd_valid && cmd_write;
  assign rd_cmd = cmd_valid && !cmd_write;

  always_ff @(posedge clk) begin
    if (!rst_n) data_due <= 1'b0;
    else        data_due <= wr_cmd;
  end

  logic [DW-1:0]    wdata [LANES];
  logic [DW-1:0]    adata [LANES];
  logic [DW-1:0]    rdata [LANES];
  logic [DW-1:0]    ev_data [LANES];
  logic [DW-1:0]    fwd [LANES];
  logic [LANES-1:0] hit, ev_mask;
  logic [AW-1:0]    ev_addr;
  logic [AW-1:0]    s_addr [DEPTH];
  logic [LANES-1:0] s_mask [DEPTH];
  logic [DW-1:0]    s_data [DEPTH][LANES];

  assign wdata[0] = wr_data0;
  assign wdata[1] = wr_data1;
  assign adata[0] = arr_rdata0;
  assign adata[1] = arr_rdata1;

  lwb_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(wr_cmd), .push_addr(cmd_addr),
    .push_mask(lane_mask(cmd_ddr, cmd_lane)), .data_due(data_due), .wdata(wdata),
    .s_addr(s_addr), .s_mask(s_mask), .s_data(s_data), .evict(evict),
    .ev_addr(ev_addr), .ev_mask(ev_mask), .ev_data(ev_data)
  );

  lwb_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_match (
    .q_addr(cmd_addr), .s_addr(s_addr), .s_mask(s_mask), .s_data(s_data),
    .data_due(data_due), .wdata(wdata), .hit(hit), .fwd(fwd)
  );

  lwb_merge #(.DW(DW)) u_merge (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_cmd), .hit(hit), .fwd(fwd),
    .arr_data(adata), .rd_valid(rd_valid), .rd_data(rdata)
  );

  assign arr_we     = evict;
  assign arr_waddr  = ev_addr;
  assign arr_wmask  = ev_mask;
  assign arr_wdata0 = ev_data[0];
  assign arr_wdata1 = ev_data[1];
  assign arr_re     = rd_cmd;
  assign arr_raddr  = cmd_addr;
  assign rd_data0   = rdata[0];
  assign rd_data1   = rdata[1];
endmodule

// File: rtl/lwb_checker.sv
module lwb_checker #(
  parameter int DEPTH = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_write,
  input logic       arr_we,
  input logic [1:0] arr_wmask,
  input logic       arr_re,
  input logic       rd_valid
);
  localparam int OW = $clog2(DEPTH + 1);
  logic [OW-1:0] occ;
  logic          started;

  // independent occupancy count: grows with writes until full
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ     <= '0;
      started <= 1'b0;
    end else begin
      started <= 1'b1;
      if (cmd_valid && cmd_write && occ != OW'(DEPTH)) occ <= occ + 1'b1;
    end
  end

  p_retire_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write) |-> (arr_we == (occ == OW'(DEPTH))));

  p_read_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (started && $past(cmd_valid && !cmd_write)));

  p_mask_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_wmask != 2'b00));

  p_retire_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (cmd_valid && cmd_write));

  p_port_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_we && arr_re));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !rd_valid);
endmodule

bind late_write_buf lwb_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .arr_we(arr_we), .arr_wmask(arr_wmask), .arr_re(arr_re), .rd_valid(rd_valid)
);

// File: tb/late_write_buf_tb.sv
module late_write_buf_tb;
  localparam int AW = 4, DW = 8, DEPTH = 2, NA = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_write = 0, cmd_ddr = 0, cmd_lane = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] wr_data0 = '0, wr_data1 = '0;
  logic arr_we, arr_re, rd_valid;
  logic [AW-1:0] arr_waddr, arr_raddr;
  logic [1:0] arr_wmask;
  logic [DW-1:0] arr_wdata0, arr_wdata1, rd_data0, rd_data1;
  logic [DW-1:0] arr_rdata0 = '0, arr_rdata1 = '0;

  always #4 clk = ~clk;  // 125 MHz

  late_write_buf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dut (.*);

  // array model with one-cycle read
  logic [DW-1:0] mem [NA][2];
  always @(posedge clk) begin
    if (arr_we) begin
      if (arr_wmask[0]) mem[arr_waddr][0] <= arr_wdata0;
      if (arr_wmask[1]) mem[arr_waddr][1] <= arr_wdata1;
    end
    if (arr_re) begin
      arr_rdata0 <= mem[arr_raddr][0];
      arr_rdata1 <= mem[arr_raddr][1];
    end
  end

  int errors = 0, checks = 0, nw = 0;
  bit done = 0;
  logic [DW-1:0] gold [NA][2];
  logic [DW-1:0] pend0 = '0, pend1 = '0;
  logic pend = 0;
  logic [AW-1:0] h_addr [8];
  logic [1:0]    h_mask [8];
  logic [DW-1:0] h_d0 [8], h_d1 [8];

  function automatic logic [DW-1:0] init_val(int a, int l);
    return DW'(a * 7 + l * 3 + 8'h55);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational outputs, then registered ones
  task automatic cyc(bit v, bit w, bit ddr, bit ln, int a, logic [DW-1:0] d0, logic [DW-1:0] d1);
    logic [1:0] m;
    bit rd;
    logic [DW-1:0] e0, e1;
    int k;
    cmd_valid = v; cmd_write = w; cmd_ddr = ddr; cmd_lane = ln; cmd_addr = AW'(a);
    // R2: outside a data cycle the data inputs carry junk
    wr_data0 = pend ? pend0 : ~DW'(a * 13);
    wr_data1 = pend ? pend1 : DW'(a * 5 + 1);
    pend = 0;
    rd = v && !w;
    e0 = gold[a][0]; e1 = gold[a][1];
    #1;
    if (v && w) begin
      m = ddr ? 2'b11 : (ln ? 2'b10 : 2'b01);
      chk("R3 arr_we on write", 32'(arr_we), 32'(nw >= DEPTH));
      if (nw >= DEPTH) begin
        k = (nw - DEPTH) % 8;
        chk("R3 retired address", 32'(arr_waddr), 32'(h_addr[k]));
        chk("R8 retired mask", 32'(arr_wmask), 32'(h_mask[k]));
        if (h_mask[k][0]) chk("R3 retired lane0", 32'(arr_wdata0), 32'(h_d0[k]));
        if (h_mask[k][1]) chk("R3 retired lane1", 32'(arr_wdata1), 32'(h_d1[k]));
      end
      k = nw % 8;
      h_addr[k] = AW'(a); h_mask[k] = m; h_d0[k] = d0; h_d1[k] = d1;
      nw++;
      if (m[0]) gold[a][0] = d0;
      if (m[1]) gold[a][1] = d1;
      pend = 1; pend0 = d0; pend1 = d1;
    end else begin
      chk("R9 no arr_we without write", 32'(arr_we), 32'd0);
    end
    if (rd) begin
      chk("R10 arr_re", 32'(arr_re), 32'd1);
      chk("R10 arr_raddr", 32'(arr_raddr), 32'(a));
    end
    @(negedge clk);
    chk("R4 rd_valid timing", 32'(rd_valid), 32'(rd));
    if (rd) begin
      chk("R5 R6 R7 lane0 data", 32'(rd_data0), 32'(e0));
      chk("R5 R6 R7 lane1 data", 32'(rd_data1), 32'(e1));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int a = 0; a < NA; a++)
      for (int l = 0; l < 2; l++) begin
        mem[a][l] = init_val(a, l);
        gold[a][l] = init_val(a, l);
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_valid after reset", 32'(rd_valid), 32'd0);
    chk("R1 arr_we after reset", 32'(arr_we), 32'd0);
    // R1 R4: empty buffer, array contents everywhere
    for (int a = 0; a < NA; a++) cyc(1, 0, 0, 0, a, 0, 0);
    // R5: write then read at once, every address
    for (int a = 0; a < NA; a++) begin
      cyc(1, 1, 1, 0, a, DW'(a * 17 + 2), DW'(a * 9 + 100));
      cyc(1, 0, 0, 0, a, 0, 0);
    end
    // R6: same address twice, both buffered
    for (int a = 0; a < NA; a++) begin
      cyc(1, 1, 1, 0, a, DW'(a + 1), DW'(a + 2));
      cyc(1, 1, 1, 0, a, DW'(a + 40), DW'(a + 80));
      cyc(1, 0, 0, 0, a, 0, 0);
    end
    // R7: single-lane writes over double-lane data, read back-to-back
    for (int a = 0; a < NA; a++) begin
      cyc(1, 1, 0, a[0], a, DW'(a * 3 + 7), DW'(a * 11 + 5));
      cyc(1, 0, 0, 0, a, 0, 0);
      cyc(0, 0, 0, 0, a, 0, 0);
      cyc(1, 0, 0, 0, a, 0, 0);
    end
    // R9: idle and read cycles do not retire
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, i, 0, 0);
    for (int a = 0; a < NA; a++) cyc(1, 0, 0, 0, a, 0, 0);
    // mixed sweep over a narrow address range
    lf = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0] | lf[1], lf[2], lf[3], lf[4], int'(lf[7:5]) & (i < 2000 ? 3 : 7),
          DW'(i * 3 + lf[15:8]), DW'(i * 5 ^ lf[11:4]));
    end
    // flush buffered writes to the array, then read through it
    for (int i = 0; i < DEPTH; i++) cyc(1, 1, 1, 0, NA - 1, DW'(i + 9), DW'(i + 19));
    for (int a = 0; a < NA; a++) cyc(1, 0, 0, 0, a, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule